// File: doc/BRIEF.md
# Chained Converter Serial Readout Port

This block is the digital readout side of a 14-bit sampling converter whose result register also serves as one stage of a longer serial chain. A host raises the convert line while the serial clock is low. That starts a conversion and puts the port in chain readback mode. After a fixed number of system-clock cycles, a behavioural converter model delivers its result. The port loads that result and drives the most significant bit on the serial output at once, without waiting for a clock edge.

Each falling edge of the serial clock after the load moves the register up by one place. The output then shows the next lower bit, and the serial data input is captured into the vacated low end. When several ports are wired output-to-input, they act as one long shift register. N ports need 14 × N clock falls to read back completely.

The convert, serial clock and serial data inputs are brought into the system clock domain through synchronisers. Edges are detected there. Dropping the convert line ends the readback and returns the output to its idle-low level.

Top module: `chain_adc_port`

## Requirements
- R1: While the convert line is low, the serial output is low, whatever the serial data input does.
- R2: A rising convert edge starts a conversion only when the synchronised serial clock is low at that moment; a rise seen with the clock high leaves the port idle and the output low.
- R3: A started conversion lasts CONV_CYCLES system clocks, during which the output stays low; when it completes, the result MSB appears on the output with no serial clock edge needed.
- R4: Serial clock falls during the conversion phase have no effect, including a fall detected in the same cycle as the conversion-done strobe; the full result still reads out MSB first afterwards.
- R5: In readback, each serial clock fall advances the output by one bit, so the 14 result bits leave most significant first.
- R6: The serial data level at each clock fall enters the register's low end; after its own 14 bits the output repeats the received bits in arrival order, as a chained downstream stage would need.
- R7: A falling convert edge, during conversion or readback, returns the port to idle with the output low; a following conversion behaves as a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cnvIn | input | 1 | Convert / chain-mode select line (asynchronous) |
| sckIn | input | 1 | Serial clock from the host (asynchronous) |
| sdiIn | input | 1 | Serial data from the upstream chain stage (asynchronous) |
| sampleIn | input | 14 | Value the behavioural converter returns as its result |
| sdoOut | output | 1 | Serial data toward the host or the downstream stage |

## Verification
Two events can land in the same system clock cycle: the conversion-done load and a detected serial clock fall. The bench counts the synchroniser and edge-detector stages on both paths. It then drops the serial clock exactly CONV_CYCLES+1 clocks after raising the convert line, so that the fall is detected in the load cycle. The fall must be ignored. The scoreboard then expects all 14 result bits, MSB first, on the next 14 falls. A shifted or missing bit shows that the fall was acted on.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CONVERT = 2'd1,
    PH_READ    = 2'd2
  } phase_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic clear;
    logic drive;
  } ctlStrobes_t;

endpackage

// File: rtl/chain_adc_sync.sv
module chain_adc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/chain_adc_core.sv
module chain_adc_core #(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= sampleIn;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R3
endmodule

// File: rtl/chain_adc_ctrl.sv
module chain_adc_ctrl
  import chain_adc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cnvS,
  input  logic        sckS,
  input  logic        coreDone,
  output logic        coreStart,
  output logic        coreAbort,
  output ctlStrobes_t strb
);
  phase_t phase, phaseNext;
  logic   cnvPrev, sckPrev;
  logic   cnvRise, cnvFall, sckFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnvPrev <= 1'b0;
      sckPrev <= 1'b0;
    end else begin
      phase   <= phaseNext;
      cnvPrev <= cnvS;
      sckPrev <= sckS;
    end
  end

  assign cnvRise = cnvS & ~cnvPrev;
  assign cnvFall = ~cnvS & cnvPrev;
  assign sckFall = ~sckS & sckPrev;

  always_comb begin
    phaseNext  = phase;
    coreStart  = 1'b0;
    coreAbort  = 1'b0;
    strb       = '0;
    strb.drive = (phase == PH_READ);
    unique case (phase)
      PH_IDLE: begin
        if (cnvRise && !sckS) begin
          coreStart = 1'b1;
          phaseNext = PH_CONVERT;
        end
      end
      PH_CONVERT: begin
        if (cnvFall) begin
          coreAbort  = 1'b1;
          strb.clear = 1'b1;
          phaseNext  = PH_IDLE;
        end else if (coreDone) begin
          strb.load = 1'b1;
          phaseNext = PH_READ;
        end
      end
      PH_READ: begin
        if (cnvFall) begin
          strb.clear = 1'b1;
          phaseNext  = PH_IDLE;
        end else if (sckFall) begin
          strb.shift = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  AST_START_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_CONVERT) |-> !$past(sckS));  // R2
  AST_LOAD_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CONVERT && coreDone && cnvS) |=> (phase == PH_READ));  // R3
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!cnvS && !cnvPrev) |-> !strb.drive);  // R1
  AST_FALL_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cnvFall |=> (phase == PH_IDLE));  // R7
endmodule

// File: rtl/chain_adc_datapath.sv
module chain_adc_datapath
  import chain_adc_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] loadValue,
  input  logic              sdiS,
  output logic              sdo
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shReg <= '0;
    else if (strb.clear)  shReg <= '0;
    else if (strb.load)   shReg <= loadValue;
    else if (strb.shift)  shReg <= {shReg[MSB-1:0], sdiS};
  end

  assign sdo = strb.drive ? shReg[MSB] : 1'b0;

  AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (shReg[MSB] == $past(shReg[MSB-1])));  // R5
  AST_TAIL_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (shReg[0] == $past(sdiS)));  // R6
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (shReg == $past(loadValue)));  // R3
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port
  import chain_adc_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvIn,
  input  logic              sckIn,
  input  logic              sdiIn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdoOut
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] rawIn, syncOut;
  logic              cnvS, sckS, sdiS;
  logic              coreStart, coreAbort, coreDone;
  logic [DATA_W-1:0] coreResult;
  ctlStrobes_t       strb;

  assign rawIn = {cnvIn, sckIn, sdiIn};
  assign {cnvS, sckS, sdiS} = syncOut;

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    chain_adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[i]),
      .q   (syncOut[i])
    );
  end

  chain_adc_core #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_core (
    .clk     (clk),
    .rstN    (rstN),
    .start   (coreStart),
    .abort   (coreAbort),
    .sampleIn(sampleIn),
    .done    (coreDone),
    .result  (coreResult)
  );

  chain_adc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cnvS     (cnvS),
    .sckS     (sckS),
    .coreDone (coreDone),
    .coreStart(coreStart),
    .coreAbort(coreAbort),
    .strb     (strb)
  );

  chain_adc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadValue(coreResult),
    .sdiS     (sdiS),
    .sdo      (sdoOut)
  );
endmodule

// File: tb/tb_chain_adc_port.sv
module tb_chain_adc_port;
  localparam int DATA_W      = 14;
  localparam int CONV_CYCLES = 40;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cnvIn = 1'b0;
  logic              sckIn = 1'b0;
  logic              sdiIn = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic              sdoOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct { logic v; string tag; } expItem_t;
  expItem_t expQ[$];
  event sampleEv;

  always #2 clk = ~clk;

  chain_adc_port #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sckIn(sckIn),
    .sdiIn(sdiIn), .sampleIn(sampleIn), .sdoOut(sdoOut)
  );

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sdo actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pushWord(logic [DATA_W-1:0] w, string tag);
    for (int i = DATA_W - 1; i >= 0; i--) expQ.push_back('{w[i], tag});
  endtask

  task automatic pushBits(logic [31:0] pat, int len, string tag);
    for (int i = len - 1; i >= 0; i--) expQ.push_back('{pat[i], tag});
  endtask

  // Samples sdo, then pulses sck with the next upstream bit on sdi.
  task automatic readBits(int n, logic [31:0] sdiPat, int sdiLen);
    for (int i = 0; i < n; i++) begin
      waitClk(2);
      -> sampleEv;
      waitClk(1);
      sckIn = 1'b1;
      sdiIn = (i < sdiLen) ? sdiPat[sdiLen-1-i] : 1'b0;
      waitClk(4);
      sckIn = 1'b0;
      waitClk(4);
    end
    sdiIn = 1'b0;
  endtask

  always @(sampleEv) begin
    expItem_t it;
    if (expQ.size() == 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: sdo actual %b expected <none>", sdoOut);
    end else begin
      it = expQ.pop_front();
      check(it.tag, sdoOut, it.v);
    end
  end

  initial begin
    waitClk(200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    check("R1 reset", sdoOut, 1'b0);
    sdiIn = 1'b1;
    waitClk(6);
    check("R1 sdi high cnv low", sdoOut, 1'b0);
    sdiIn = 1'b0;

    // Normal conversion with upstream bits following (R3, R5, R6)
    sampleIn = 14'h2A5C;
    cnvIn = 1'b1;
    waitClk(CONV_CYCLES / 2);
    check("R3 low during conversion", sdoOut, 1'b0);
    waitClk(CONV_CYCLES / 2 + 10);
    check("R3 MSB before sck", sdoOut, 1'b1);
    pushWord(14'h2A5C, "R5 own bits");
    pushBits(32'h000000B3, 8, "R6 upstream bits");
    readBits(22, 32'h000000B3, 8);
    cnvIn = 1'b0;
    waitClk(6);
    check("R7 cnv fall idle", sdoOut, 1'b0);
    sdiIn = 1'b1;
    waitClk(6);
    check("R1 idle after readback", sdoOut, 1'b0);
    sdiIn = 1'b0;

    // Rise with sck high must not start (R2)
    sampleIn = 14'h3FFF;
    sckIn = 1'b1;
    waitClk(6);
    cnvIn = 1'b1;
    waitClk(CONV_CYCLES + 10);
    check("R2 no start sck high", sdoOut, 1'b0);
    sckIn = 1'b0;
    waitClk(CONV_CYCLES + 10);
    check("R2 still idle", sdoOut, 1'b0);
    cnvIn = 1'b0;
    waitClk(6);

    // sck activity during conversion ignored (R4)
    sampleIn = 14'h3001;
    cnvIn = 1'b1;
    waitClk(6);
    for (int k = 0; k < 3; k++) begin
      sckIn = 1'b1; waitClk(4);
      sckIn = 1'b0; waitClk(4);
    end
    waitClk(CONV_CYCLES);
    check("R4 MSB after sck in conversion", sdoOut, 1'b1);
    pushWord(14'h3001, "R4 full word");
    readBits(14, 32'h0, 0);
    cnvIn = 1'b0;
    waitClk(6);

    // sck fall coincides with load (R4)
    sampleIn = 14'h2C35;
    cnvIn = 1'b1;
    waitClk(3);
    sckIn = 1'b1;
    waitClk(CONV_CYCLES - 2);
    sckIn = 1'b0;
    waitClk(8);
    check("R4 coincident MSB", sdoOut, 1'b1);
    pushWord(14'h2C35, "R4 coincident word");
    readBits(14, 32'h0, 0);
    cnvIn = 1'b0;
    waitClk(6);

    // Abort mid-conversion, then fresh conversion (R7)
    sampleIn = 14'h3FFF;
    cnvIn = 1'b1;
    waitClk(CONV_CYCLES / 2);
    cnvIn = 1'b0;
    waitClk(CONV_CYCLES + 10);
    check("R7 abort keeps low", sdoOut, 1'b0);
    sampleIn = 14'h1234;
    cnvIn = 1'b1;
    waitClk(CONV_CYCLES + 10);
    check("R7 restart MSB", sdoOut, 1'b0);
    pushWord(14'h1234, "R7 restart word");
    pushBits(32'h5, 3, "R6 tail bits");
    readBits(17, 32'h5, 3);
    cnvIn = 1'b0;
    waitClk(6);
    check("R1 final idle", sdoOut, 1'b0);

    if (expQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule